// File: doc/BRIEF.md
# Garbled AND Gate Engine

This block garbles a single two-input AND gate for a garbled-circuit garbler that uses free-XOR label pairs. A request carries the zero-labels of both input wires, the global offset that separates every wire's two labels, and an index that names the gate. The block returns the zero-label of the output wire and a three-entry garbling table. The output label is fed to later gates as one of their inputs. The table is sent to the evaluator.

Four identical hash lanes run side by side, one for each position of the permuted truth table. Each lane is an iterative SHA-1 compression engine that does one round per clock. A lane hashes one padded block built from the two selected input labels, the gate index and the lane's position. It keeps the upper 80 bits of the digest.

The output zero-label is chosen so that the entry at permuted position 0 would be all zeros. That entry is therefore not emitted, and only positions 1 to 3 leave the block. A new gate is taken only when all four lanes are idle.

Top module: `gand_engine`

## Requirements
- R1: While reset is held and right after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: A request is taken on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle until the result appears, `in_ready` is 0, and `in_valid` with any data during that time is ignored: the result that follows belongs to the request that was taken.
- R3: `out_valid` is high for exactly one cycle, starting after the 81st rising edge that follows the accepting edge. `in_ready` is 1 again in that same cycle.
- R4: For each permuted position p (2 bits), the row hash is the upper 80 bits of the SHA-1 digest of one 512-bit block. From the most significant bit down, that block holds: the selected A label (80 bits), the selected B label (80 bits), the gate index (32 bits), p (2 bits), a single 1 bit, zero bits, and the 64-bit message length of 194.
- R5: Permuted position p = {pa', pb'} selects the A label whose bit 0 equals pa' and the B label whose bit 0 equals pb'. Bit 0 of every label is its permute bit.
- R6: The output zero-label Z is chosen so that the row hash at position 0, XORed with the output label for that position's AND value, is zero. With zero-labels A0 and B0 and offset D, Z equals H0, or H0 XOR D when A0[0] and B0[0] are both 1.
- R7: The table entry for position p (1 to 3) is Hp XOR Z, further XORed with D when the AND of the position's two wire values is 1. It sits at bits [80p-1 : 80(p-1)] of `out_tbl`.
- R8: With free-XOR pairs (the one-label of each wire is its zero-label XOR D, where D[0]=1), an evaluator holding any pair of input labels gets the correct output label. It hashes its pair at the position given by their permute bits. At position 0 the hash is the label; at any other position it XORs the hash with the table entry.
- R9: Each hash lane produces the standard SHA-1 digest for a single padded block. For the message "abc" the result is a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R10: `out_lbl` and `out_tbl` change only on the cycle where `out_valid` is 1, and otherwise hold the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine idle, request can be taken |
| in_a0 | input | 80 | Zero-label of input wire A |
| in_b0 | input | 80 | Zero-label of input wire B |
| in_delta | input | 80 | Global free-XOR offset, bit 0 set |
| in_gate | input | 32 | Gate index mixed into every hash |
| out_valid | output | 1 | One-cycle result strobe |
| out_lbl | output | 80 | Zero-label of the output wire |
| out_tbl | output | 240 | Table entries for permuted positions 1 (low) to 3 (high) |

## Verification
The gate is garbled with all four combinations of the two input permute bits, under two different offsets. Each combination moves a different truth-table value onto the reduced position, so a wrong permutation or a wrong choice of the output label shows up as a mismatch in a specific entry.

For every gate, the evaluator's decryption is repeated for all four input value pairs. This tells a table that is merely self-consistent apart from one that decodes to the right AND result.

A request is also presented while the engine is busy, to show that it leaves the pending result untouched. The lane itself is checked alone against the standard digest of "abc".

// File: rtl/gand_pkg.sv
`timescale 1ns/1ps
package gand_pkg;
  localparam int WORD_W = 32;
  localparam int BLK_W  = 512;
  localparam int DIG_W  = 160;
  localparam int LEN_W  = 64;
  localparam int ROUNDS = 80;
  localparam int WORDS  = BLK_W / WORD_W;
  localparam int RND_W  = $clog2(ROUNDS);

  localparam logic [WORD_W-1:0] IV0 = 32'h67452301;
  localparam logic [WORD_W-1:0] IV1 = 32'hEFCDAB89;
  localparam logic [WORD_W-1:0] IV2 = 32'h98BADCFE;
  localparam logic [WORD_W-1:0] IV3 = 32'h10325476;
  localparam logic [WORD_W-1:0] IV4 = 32'hC3D2E1F0;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/gand_sha1_core.sv
`timescale 1ns/1ps
module gand_sha1_core
  import gand_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] block,
  output logic             busy,
  output logic             done,
  output logic [DIG_W-1:0] digest
);
  localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

  logic [WORD_W-1:0] a_q, b_q, c_q, d_q, e_q, a_d, b_d, c_d, d_d, e_d;
  logic [WORDS-1:0][WORD_W-1:0] w_q, w_d;
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic run_q, run_d, done_q, done_d;
  logic [WORD_W-1:0] f, k, tmp;
  logic dp_en;

  always_comb begin
    if (rnd_q < RND_W'(20)) begin
      f = (b_q & c_q) | (~b_q & d_q);               k = 32'h5A827999;
    end else if (rnd_q < RND_W'(40)) begin
      f = b_q ^ c_q ^ d_q;                          k = 32'h6ED9EBA1;
    end else if (rnd_q < RND_W'(60)) begin
      f = (b_q & c_q) | (b_q & d_q) | (c_q & d_q);  k = 32'h8F1BBCDC;
    end else begin
      f = b_q ^ c_q ^ d_q;                          k = 32'hCA62C1D6;
    end
    tmp = rotl(a_q, 5) + f + e_q + k + w_q[0];
  end

  always_comb begin
    a_d = a_q; b_d = b_q; c_d = c_q; d_d = d_q; e_d = e_q;
    w_d = w_q; rnd_d = rnd_q; run_d = run_q; done_d = 1'b0;
    if (start) begin
      a_d = IV0; b_d = IV1; c_d = IV2; d_d = IV3; e_d = IV4;
      for (int j = 0; j < WORDS; j++) w_d[j] = block[BLK_W-1-WORD_W*j -: WORD_W];
      rnd_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      a_d = tmp; b_d = a_q; c_d = rotl(b_q, 30); d_d = c_q; e_d = d_q;
      for (int j = 0; j < WORDS-1; j++) w_d[j] = w_q[j+1];
      w_d[WORDS-1] = rotl(w_q[13] ^ w_q[8] ^ w_q[2] ^ w_q[0], 1);
      rnd_d = rnd_q + 1'b1;
      if (rnd_q == LAST) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  assign dp_en = start | run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      rnd_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      if (dp_en) rnd_q <= rnd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dp_en) begin
      a_q <= a_d; b_q <= b_d; c_q <= c_d; d_q <= d_d; e_q <= e_d;
      w_q <= w_d;
    end
  end

  assign busy   = run_q;
  assign done   = done_q;
  assign digest = {IV0 + a_q, IV1 + b_q, IV2 + c_q, IV3 + d_q, IV4 + e_q};

  // R2: a lane is never restarted in the middle of a hash
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q);
  // R3: completion is a single-cycle strobe
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/gand_row_hash.sv
`timescale 1ns/1ps
module gand_row_hash
  import gand_pkg::*;
#(
  parameter int LBL_W = 80,
  parameter int IDX_W = 32,
  parameter int ROW   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LBL_W-1:0] lbl_a,
  input  logic [LBL_W-1:0] lbl_b,
  input  logic [IDX_W-1:0] gate,
  output logic             done,
  output logic [LBL_W-1:0] hash
);
  localparam int ROW_W = 2;
  localparam int MSG_W = 2*LBL_W + IDX_W + ROW_W;
  localparam int PAD_W = BLK_W - MSG_W - 1 - LEN_W;

  logic [BLK_W-1:0] blk;
  logic [DIG_W-1:0] dig;
  logic             busy;

  assign blk = {lbl_a, lbl_b, gate, ROW_W'(ROW), 1'b1, {PAD_W{1'b0}}, LEN_W'(MSG_W)};

  gand_sha1_core u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .block(blk),
    .busy(busy), .done(done), .digest(dig)
  );

  assign hash = dig[DIG_W-1 -: LBL_W];

  // R4: the lane is idle whenever a new block is offered
  p_lane_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R9: a finished digest is fully defined
  p_digest_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$isunknown(dig));
endmodule

// File: rtl/gand_engine.sv
`timescale 1ns/1ps
module gand_engine #(
  parameter int LBL_W = 80,
  parameter int IDX_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LBL_W-1:0]   in_a0,
  input  logic [LBL_W-1:0]   in_b0,
  input  logic [LBL_W-1:0]   in_delta,
  input  logic [IDX_W-1:0]   in_gate,
  output logic               out_valid,
  output logic [LBL_W-1:0]   out_lbl,
  output logic [3*LBL_W-1:0] out_tbl
);
  localparam int ROWS = 4;
  localparam int LAT  = gand_pkg::ROUNDS + 2;
  localparam int LAT_W = $clog2(LAT + 2);

  logic busy_q, busy_d, accept;
  logic pa_q, pb_q;
  logic [LBL_W-1:0] delta_q;
  logic [ROWS-1:0]  row_done;
  logic [LBL_W-1:0] row_h [ROWS];
  logic ov_q;
  logic [LBL_W-1:0]   lbl_q, lbl_d;
  logic [3*LBL_W-1:0] tbl_q, tbl_d;

  assign accept   = in_valid & ~busy_q;
  assign in_ready = ~busy_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic IA = ((r / 2) % 2) == 1;
    localparam logic IB = (r % 2) == 1;
    logic [LBL_W-1:0] sel_a, sel_b;
    assign sel_a = in_a0 ^ ({LBL_W{IA ^ in_a0[0]}} & in_delta);
    assign sel_b = in_b0 ^ ({LBL_W{IB ^ in_b0[0]}} & in_delta);
    gand_row_hash #(.LBL_W(LBL_W), .IDX_W(IDX_W), .ROW(r)) u_lane (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .lbl_a(sel_a), .lbl_b(sel_b), .gate(in_gate),
      .done(row_done[r]), .hash(row_h[r])
    );
  end

  always_comb begin
    logic va, vb;
    lbl_d = row_h[0] ^ ({LBL_W{pa_q & pb_q}} & delta_q);
    tbl_d = '0;
    for (int i = 1; i < ROWS; i++) begin
      va = (i >= 2) ^ pa_q;
      vb = (i % 2 == 1) ^ pb_q;
      tbl_d[(i-1)*LBL_W +: LBL_W] = row_h[i] ^ lbl_d ^ ({LBL_W{va & vb}} & delta_q);
    end
    busy_d = busy_q;
    if (accept)           busy_d = 1'b1;
    else if (row_done[0]) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ov_q   <= 1'b0;
      lbl_q  <= '0;
      tbl_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ov_q   <= row_done[0];
      if (row_done[0]) begin
        lbl_q <= lbl_d;
        tbl_q <= tbl_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      delta_q <= in_delta;
      pa_q    <= in_a0[0];
      pb_q    <= in_b0[0];
    end
  end

  assign out_valid = ov_q;
  assign out_lbl   = lbl_q;
  assign out_tbl   = tbl_q;

  // checker counter: edges since the accepting edge
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (accept) lat_q <= LAT_W'(1);
    else if (busy_q) lat_q <= lat_q + 1'b1;
  end

  // R2: taking a request closes the input
  p_accept_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R3: the result strobe lasts a single cycle
  p_out_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R3: fixed distance from acceptance to the strobe
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lat_q == LAT_W'(LAT));
  // R5: all four permuted lanes finish together
  p_lockstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|row_done) |-> (&row_done));
  // R10: results hold between strobes
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_lbl) && $stable(out_tbl)));
endmodule

// File: tb/gand_engine_bench.sv
`timescale 1ns/1ps
module gand_engine_bench;
  localparam int LW = 80;
  localparam int GW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [LW-1:0] in_a0 = '0, in_b0 = '0, in_delta = '0;
  logic [GW-1:0] in_gate = '0;
  logic          out_valid;
  logic [LW-1:0] out_lbl;
  logic [3*LW-1:0] out_tbl;

  gand_engine u_gand_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a0(in_a0), .in_b0(in_b0), .in_delta(in_delta), .in_gate(in_gate),
    .out_valid(out_valid), .out_lbl(out_lbl), .out_tbl(out_tbl)
  );

  // standalone lane for the known-answer digest
  logic         s_start = 1'b0;
  logic [511:0] s_block = '0;
  logic         s_busy, s_done;
  logic [159:0] s_dig;
  gand_sha1_core u_abc (
    .clk(clk), .rst_n(rst_n), .start(s_start), .block(s_block),
    .busy(s_busy), .done(s_done), .digest(s_dig)
  );

  int total = 0;
  int fails = 0;
  logic [63:0] seed = 64'h0DDC0FFEE1234567;

  task automatic chk(input bit ok, input string req, input logic [239:0] act, input logic [239:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] sha1_ref(input logic [511:0] m);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = m[511-32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE; d = 32'h10325476; e = 32'hC3D2E1F0;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);        k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                 k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                 k = 32'hCA62C1D6; end
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    return {32'h67452301 + a, 32'hEFCDAB89 + b, 32'h98BADCFE + c, 32'h10325476 + d, 32'hC3D2E1F0 + e};
  endfunction

  // R4: row hash over the padded block
  function automatic logic [LW-1:0] row_hash(input logic [LW-1:0] la, input logic [LW-1:0] lb,
                                             input logic [GW-1:0] g, input logic [1:0] p);
    logic [511:0] blk;
    logic [159:0] dg;
    blk = {la, lb, g, p, 1'b1, 253'b0, 64'd194};
    dg  = sha1_ref(blk);
    return dg[159:80];
  endfunction

  function automatic logic [LW-1:0] next_lbl();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    next_lbl[79:16] = seed;
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    next_lbl[15:0] = seed[47:32];
  endfunction

  task automatic run_gate(input logic pa, input logic pb, input logic [LW-1:0] dl);
    logic [LW-1:0] a0, b0, z, h, got, exp_o, la, lb;
    logic [GW-1:0] g;
    logic [1:0] p;
    logic [LW-1:0] hold_l;
    logic [3*LW-1:0] hold_t;
    int lat;
    bit ready_ok;
    a0 = next_lbl(); a0[0] = pa;
    b0 = next_lbl(); b0[0] = pb;
    g  = seed[45:14];
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready before request", 240'(in_ready), 240'(1));
    in_valid = 1'b1; in_a0 = a0; in_b0 = b0; in_delta = dl; in_gate = g;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    ready_ok = 1'b1;
    while (lat < 300) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (out_valid) break;
      if (in_ready) ready_ok = 1'b0;
      if (lat == 10) begin // R2: data offered while busy must be ignored
        in_valid = 1'b1; in_a0 = ~a0; in_b0 = ~b0; in_gate = ~g;
      end
      if (lat == 15) in_valid = 1'b0;
    end
    chk(ready_ok, "R2 in_ready low while busy", '0, '0);
    chk(lat == 81, "R3 latency", 240'(lat), 240'(81));
    chk(in_ready == 1'b1, "R3 ready with strobe", 240'(in_ready), 240'(1));
    // R5/R6: expected zero-label from position 0
    h = row_hash(a0 ^ (pa ? dl : '0), b0 ^ (pb ? dl : '0), g, 2'd0);
    z = h ^ ((pa & pb) ? dl : '0);
    chk(out_lbl == z, "R6 output zero-label", 240'(out_lbl), 240'(z));
    for (int i = 1; i < 4; i++) begin
      logic va, vb;
      logic [LW-1:0] e;
      p  = 2'(i);
      va = p[1] ^ pa; vb = p[0] ^ pb;
      e  = row_hash(a0 ^ (va ? dl : '0), b0 ^ (vb ? dl : '0), g, p) ^ z ^ ((va & vb) ? dl : '0);
      chk(out_tbl[(i-1)*LW +: LW] == e, "R7 R5 table entry", 240'(out_tbl[(i-1)*LW +: LW]), 240'(e));
    end
    // R8: evaluator decode for every value pair
    for (int v = 0; v < 4; v++) begin
      logic [1:0] vv;
      vv = 2'(v);
      la = a0 ^ (vv[1] ? dl : '0);
      lb = b0 ^ (vv[0] ? dl : '0);
      p  = {la[0], lb[0]};
      h  = row_hash(la, lb, g, p);
      got = (p == 2'd0) ? h : h ^ out_tbl[(int'(p)-1)*LW +: LW];
      exp_o = out_lbl ^ ((vv[1] & vv[0]) ? dl : '0);
      chk(got == exp_o, "R8 evaluator decode", 240'(got), 240'(exp_o));
    end
    hold_l = out_lbl; hold_t = out_tbl;
    @(negedge clk);
    chk(out_valid == 1'b0, "R3 strobe width", 240'(out_valid), 240'(0));
    repeat (3) @(negedge clk);
    chk(out_lbl == hold_l && out_tbl == hold_t, "R10 outputs hold", out_tbl, hold_t);
  endtask

  initial begin
    logic [LW-1:0] dl;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state", 240'({in_ready, out_valid}), 240'(2'b10));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after release", 240'({in_ready, out_valid}), 240'(2'b10));

    // R9: known-answer digest on a standalone lane
    s_block = {32'h61626380, 416'b0, 64'd24};
    s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    while (!s_done) @(negedge clk);
    chk(s_dig == 160'ha9993e364706816aba3e25717850c26c9cd0d89d, "R9 abc digest",
        240'(s_dig), 240'(160'ha9993e364706816aba3e25717850c26c9cd0d89d));

    for (int d = 0; d < 2; d++) begin
      dl = next_lbl();
      dl[0] = 1'b1;
      for (int pp = 0; pp < 4; pp++) run_gate(pp[1], pp[0], dl);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule